// File: doc/BRIEF.md
# Interrupt source state controller

This block keeps the per-source state of a bank of interrupt sources and turns input activity into interrupt offers for a downstream presentation unit. Each source is fixed at build time as either level-sensitive or message-signalled. It carries a target server, an active priority, a saved priority and four status flags: asserted, sent, rejected and masked-pending. Priority 0xff means masked. Source index `i` is seen from outside as global number `BASE + i`.

Offers leave one at a time through a valid/ready handshake. When several sources want to offer in the same cycle, the lowest index goes first. The presentation unit reports back through two single-cycle notifications. A reject means the offer was not taken. An EOI means a level source has been serviced.

A resend request starts a scan that visits every source in index order. The scan moves one source per cycle and waits while an offer is outstanding. A single-request register port can:
- read a source's server and priority,
- write the server and priority,
- turn a source off by parking its priority at 0xff and keeping a copy,
- turn it back on from that copy.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset every source reads server 0 and priority 0xff, all status flags are clear, and no offer is presented.
- R2: A message source (index below 4 by default) that sees an input-high cycle while unmasked offers number BASE+index with its server and priority. While masked, the same input only sets masked-pending and produces no offer.
- R3: A level source (index 4 and up by default) is offered only when it is unmasked, asserted and not sent. Offering sets sent, so toggling the input while sent is set produces no new offer. The offer check runs only when the input level changes.
- R4: A reject notification for a source sets its rejected flag and clears its sent flag, and does not re-offer the source by itself.
- R5: An EOI clears the sent flag of a level source. It leaves a message source untouched, so a rejected message source stays rejected.
- R6: A resend pulse scans all sources in index order. Level sources repeat the offer check. Message sources with rejected set clear it and are re-offered only if unmasked. Resend pulses during a scan are ignored.
- R7: A write (op 1) sets server, priority and saved priority. A message source with masked-pending set that becomes unmasked clears the flag and is offered. A level source repeats the offer check.
- R8: Off (op 2) copies the active priority into the saved priority and sets the active priority to 0xff. On (op 3) restores the active priority from the saved copy and then runs the same follow-up as a write.
- R9: A register request whose number lies outside BASE to BASE+N_SRC-1 returns error and changes no state.
- R10: An offer stays valid with its number, server and priority unchanged until it is accepted. Simultaneous requests leave in ascending index order.
- R11: The resend scan does not advance while an offer is valid or requested, so offers from a scan keep index order.
- R12: Every register request gets cfg_done_o one cycle later. A read (op 0) returns the server and active priority of the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Per-source input: event strobe (message) or level |
| cfg_valid_i | input | 1 | Register request strobe |
| cfg_op_i | input | 2 | 0 read, 1 write, 2 off, 3 on |
| cfg_num_i | input | NUM_W | Global source number |
| cfg_server_i | input | SRV_W | Server for a write |
| cfg_prio_i | input | PRIO_W | Priority for a write |
| cfg_done_o | output | 1 | Request completed |
| cfg_err_o | output | 1 | Number out of range |
| cfg_rd_server_o | output | SRV_W | Read server |
| cfg_rd_prio_o | output | PRIO_W | Read active priority |
| rej_valid_i | input | 1 | Reject notification |
| rej_num_i | input | NUM_W | Rejected global number |
| eoi_valid_i | input | 1 | EOI notification |
| eoi_num_i | input | NUM_W | EOI global number |
| resend_i | input | 1 | Start a resend scan |
| offer_valid_o | output | 1 | Offer presented |
| offer_ready_i | input | 1 | Offer accepted |
| offer_num_o | output | NUM_W | Offered global number |
| offer_server_o | output | SRV_W | Offered target server |
| offer_prio_o | output | PRIO_W | Offered priority |

## Verification
Message sources are driven with single strobes while unmasked, strobes while masked followed by an unmasking write, and two strobes in the same cycle. Together these separate immediate offers, parked masked-pending offers and the ordering among simultaneous offers. Level sources are driven with rise, fall and re-rise sequences around EOI and reject, which shows whether the sent flag blocks repeated offers and whether only a level change re-arms the check. A resend after a mix of rejected message, rejected level and masked rejected sources, with the offer held back for several cycles, checks scan order, the masked filter and the offer holding stable while stalled.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  parameter int unsigned SRV_W  = 4;
  parameter int unsigned PRIO_W = 8;

  localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

  typedef enum logic [1:0] {
    CFG_READ  = 2'd0,
    CFG_WRITE = 2'd1,
    CFG_OFF   = 2'd2,
    CFG_ON    = 2'd3
  } cfg_op_e;

  typedef struct packed {
    logic [SRV_W-1:0]  server;
    logic [PRIO_W-1:0] prio;
    logic [PRIO_W-1:0] saved;
    logic              asserted;
    logic              sent;
    logic              rejected;
    logic              mpend;
    logic              req;
  } src_state_t;

  // level offer check: unmasked, asserted and not yet sent
  function automatic src_state_t lvl_offer(src_state_t s);
    src_state_t r;
    r = s;
    if (s.prio != PRIO_MASKED && s.asserted && !s.sent) begin
      r.sent = 1'b1;
      r.req  = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,
  input  logic              rej_i,
  input  logic              eoi_i,
  input  logic              cfg_we_i,
  input  cfg_op_e           cfg_op_i,
  input  logic [SRV_W-1:0]  cfg_server_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic              scan_i,
  input  logic              grant_i,
  output logic              req_o,
  output logic [SRV_W-1:0]  server_o,
  output logic [PRIO_W-1:0] prio_o
);
  src_state_t st_q, st_d;

  always_comb begin
    st_d     = st_q;
    st_d.req = st_q.req & ~grant_i;

    if (rej_i) begin
      st_d.rejected = 1'b1;
      st_d.sent     = 1'b0;
    end

    if (eoi_i && IS_LEVEL) st_d.sent = 1'b0;

    if (cfg_we_i) begin
      unique case (cfg_op_i)
        CFG_WRITE: begin
          st_d.server = cfg_server_i;
          st_d.prio   = cfg_prio_i;
          st_d.saved  = cfg_prio_i;
        end
        CFG_OFF: begin
          st_d.saved = st_q.prio;
          st_d.prio  = PRIO_MASKED;
        end
        CFG_ON:  st_d.prio = st_q.saved;
        default: ;
      endcase
      if (IS_LEVEL) begin
        st_d = lvl_offer(st_d);
      end else if (st_d.mpend && st_d.prio != PRIO_MASKED) begin
        st_d.mpend = 1'b0;
        st_d.req   = 1'b1;
      end
    end

    if (IS_LEVEL) begin
      if (lvl_i != st_d.asserted) begin
        st_d.asserted = lvl_i;
        st_d          = lvl_offer(st_d);
      end
    end else if (lvl_i) begin
      if (st_d.prio == PRIO_MASKED) st_d.mpend = 1'b1;
      else                          st_d.req   = 1'b1;
    end

    if (scan_i) begin
      if (IS_LEVEL) begin
        st_d = lvl_offer(st_d);
      end else if (st_d.rejected) begin
        st_d.rejected = 1'b0;
        if (st_d.prio != PRIO_MASKED) st_d.req = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= '0;
      st_q.prio   <= PRIO_MASKED;
      st_q.saved  <= PRIO_MASKED;
    end else begin
      st_q <= st_d;
    end
  end

  assign req_o    = st_q.req;
  assign server_o = st_q.server;
  assign prio_o   = st_q.prio;
endmodule

// File: rtl/irq_src_arb.sv
module irq_src_arb
  import irq_src_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_SRC-1:0]              req_i,
  input  logic [N_SRC-1:0][SRV_W-1:0]   srv_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0]  prio_i,
  input  logic                          ready_i,
  output logic [N_SRC-1:0]              grant_o,
  output logic                          valid_o,
  output logic [IDX_W-1:0]              idx_o,
  output logic [SRV_W-1:0]              srv_o,
  output logic [PRIO_W-1:0]             prio_o
);
  logic             slot_free;
  logic             found;
  logic [IDX_W-1:0] pick;

  assign slot_free = !valid_o || ready_i;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && !found) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (slot_free && found) grant_o[pick] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      srv_o   <= '0;
      prio_o  <= PRIO_MASKED;
    end else if (slot_free) begin
      valid_o <= found;
      if (found) begin
        idx_o  <= pick;
        srv_o  <= srv_i[pick];
        prio_o <= prio_i[pick];
      end
    end
  end
endmodule

// File: rtl/irq_src_scan.sv
module irq_src_scan #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stall_i,
  output logic [N_SRC-1:0] hit_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SRC - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             step;

  assign step = busy_q && !stall_i;

  always_comb begin
    hit_o = '0;
    if (step) hit_o[idx_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (step) begin
      if (idx_q == LAST) busy_q <= 1'b0;
      else               idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int unsigned     N_SRC      = 8,
  parameter int unsigned     NUM_W      = 12,
  parameter int unsigned     BASE       = 16,
  parameter logic [N_SRC-1:0] LEVEL_MASK = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              cfg_valid_i,
  input  logic [1:0]        cfg_op_i,
  input  logic [NUM_W-1:0]  cfg_num_i,
  input  logic [SRV_W-1:0]  cfg_server_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  output logic              cfg_done_o,
  output logic              cfg_err_o,
  output logic [SRV_W-1:0]  cfg_rd_server_o,
  output logic [PRIO_W-1:0] cfg_rd_prio_o,
  input  logic              rej_valid_i,
  input  logic [NUM_W-1:0]  rej_num_i,
  input  logic              eoi_valid_i,
  input  logic [NUM_W-1:0]  eoi_num_i,
  input  logic              resend_i,
  output logic              offer_valid_o,
  input  logic              offer_ready_i,
  output logic [NUM_W-1:0]  offer_num_o,
  output logic [SRV_W-1:0]  offer_server_o,
  output logic [PRIO_W-1:0] offer_prio_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);
  localparam logic [NUM_W:0] LO = (NUM_W+1)'(BASE);
  localparam logic [NUM_W:0] HI = (NUM_W+1)'(BASE + N_SRC);

  function automatic logic in_rng(logic [NUM_W-1:0] n);
    return ({1'b0, n} >= LO) && ({1'b0, n} < HI);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(logic [NUM_W-1:0] n);
    return IDX_W'(n - NUM_W'(BASE));
  endfunction

  cfg_op_e                    cfg_op;
  logic                       cfg_ok, cfg_we;
  logic [IDX_W-1:0]           cfg_idx, rej_idx, eoi_idx, off_idx;
  logic                       rej_ok, eoi_ok;
  logic [N_SRC-1:0]           req, grant, scan_hit;
  logic [N_SRC-1:0][SRV_W-1:0]  srv_a;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_a;

  assign cfg_op  = cfg_op_e'(cfg_op_i);
  assign cfg_ok  = cfg_valid_i && in_rng(cfg_num_i);
  assign cfg_we  = cfg_ok && (cfg_op != CFG_READ);
  assign cfg_idx = to_idx(cfg_num_i);
  assign rej_ok  = rej_valid_i && in_rng(rej_num_i);
  assign rej_idx = to_idx(rej_num_i);
  assign eoi_ok  = eoi_valid_i && in_rng(eoi_num_i);
  assign eoi_idx = to_idx(eoi_num_i);

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    irq_src_slot #(.IS_LEVEL(LEVEL_MASK[g])) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lvl_i        (src_i[g]),
      .rej_i        (rej_ok && rej_idx == IDX_W'(g)),
      .eoi_i        (eoi_ok && eoi_idx == IDX_W'(g)),
      .cfg_we_i     (cfg_we && cfg_idx == IDX_W'(g)),
      .cfg_op_i     (cfg_op),
      .cfg_server_i (cfg_server_i),
      .cfg_prio_i   (cfg_prio_i),
      .scan_i       (scan_hit[g]),
      .grant_i      (grant[g]),
      .req_o        (req[g]),
      .server_o     (srv_a[g]),
      .prio_o       (prio_a[g])
    );
  end

  irq_src_arb #(.N_SRC(N_SRC)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .srv_i   (srv_a),
    .prio_i  (prio_a),
    .ready_i (offer_ready_i),
    .grant_o (grant),
    .valid_o (offer_valid_o),
    .idx_o   (off_idx),
    .srv_o   (offer_server_o),
    .prio_o  (offer_prio_o)
  );

  irq_src_scan #(.N_SRC(N_SRC)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (resend_i),
    .stall_i (offer_valid_o || (|req)),
    .hit_o   (scan_hit)
  );

  assign offer_num_o = NUM_W'(BASE) + NUM_W'(off_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_done_o      <= 1'b0;
      cfg_err_o       <= 1'b0;
      cfg_rd_server_o <= '0;
      cfg_rd_prio_o   <= '0;
    end else begin
      cfg_done_o <= cfg_valid_i;
      cfg_err_o  <= cfg_valid_i && !cfg_ok;
      if (cfg_ok && cfg_op == CFG_READ) begin
        cfg_rd_server_o <= srv_a[cfg_idx];
        cfg_rd_prio_o   <= prio_a[cfg_idx];
      end
    end
  end
endmodule

// File: rtl/irq_src_ctrl_chk.sv
module irq_src_ctrl_chk
  import irq_src_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned NUM_W = 12,
  parameter int unsigned BASE  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_valid_i,
  input logic [NUM_W-1:0]  cfg_num_i,
  input logic              cfg_done_o,
  input logic              cfg_err_o,
  input logic              offer_valid_o,
  input logic              offer_ready_i,
  input logic [NUM_W-1:0]  offer_num_o,
  input logic [SRV_W-1:0]  offer_server_o,
  input logic [PRIO_W-1:0] offer_prio_o
);
  localparam logic [NUM_W:0] LO = (NUM_W+1)'(BASE);
  localparam logic [NUM_W:0] HI = (NUM_W+1)'(BASE + N_SRC);

  a_r10_offer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_valid_o && !offer_ready_i |=> offer_valid_o && $stable(offer_num_o)
      && $stable(offer_server_o) && $stable(offer_prio_o));

  a_r2_no_masked_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_valid_o |-> offer_prio_o != PRIO_MASKED);

  a_r10_offer_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_valid_o |-> ({1'b0, offer_num_o} >= LO) && ({1'b0, offer_num_o} < HI));

  a_r12_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i |=> cfg_done_o);

  a_r9_low_num_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && ({1'b0, cfg_num_i} < LO) |=> cfg_err_o);

  a_r9_err_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> cfg_done_o);
endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(.N_SRC(N_SRC), .NUM_W(NUM_W), .BASE(BASE)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_valid_i    (cfg_valid_i),
  .cfg_num_i      (cfg_num_i),
  .cfg_done_o     (cfg_done_o),
  .cfg_err_o      (cfg_err_o),
  .offer_valid_o  (offer_valid_o),
  .offer_ready_i  (offer_ready_i),
  .offer_num_o    (offer_num_o),
  .offer_server_o (offer_server_o),
  .offer_prio_o   (offer_prio_o)
);

// File: tb/irq_src_ctrl_bench.sv
module irq_src_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src = '0;
  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_op = '0;
  logic [11:0] cfg_num = '0;
  logic [3:0]  cfg_srv = '0;
  logic [7:0]  cfg_prio = '0;
  logic        cfg_done, cfg_err;
  logic [3:0]  rd_srv;
  logic [7:0]  rd_prio;
  logic        rej_valid = 1'b0, eoi_valid = 1'b0, resend = 1'b0;
  logic [11:0] rej_num = '0, eoi_num = '0;
  logic        off_valid, off_ready = 1'b0;
  logic [11:0] off_num;
  logic [3:0]  off_srv;
  logic [7:0]  off_prio;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_src_ctrl u_irq_src_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .cfg_valid_i(cfg_valid), .cfg_op_i(cfg_op), .cfg_num_i(cfg_num),
    .cfg_server_i(cfg_srv), .cfg_prio_i(cfg_prio),
    .cfg_done_o(cfg_done), .cfg_err_o(cfg_err),
    .cfg_rd_server_o(rd_srv), .cfg_rd_prio_o(rd_prio),
    .rej_valid_i(rej_valid), .rej_num_i(rej_num),
    .eoi_valid_i(eoi_valid), .eoi_num_i(eoi_num), .resend_i(resend),
    .offer_valid_o(off_valid), .offer_ready_i(off_ready),
    .offer_num_o(off_num), .offer_server_o(off_srv), .offer_prio_o(off_prio)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] num;
    logic [3:0]  srv;
    logic [7:0]  prio;
    logic        err;
    logic [3:0]  esrv;
    logic [7:0]  eprio;
  } vec_t;

  // op: 0 read, 1 write, 2 off, 3 on
  localparam vec_t TBL [12] = '{
    '{2'd0, 12'd23, 4'd0, 8'd0,  1'b0, 4'd0, 8'hFF},
    '{2'd1, 12'd16, 4'd3, 8'd5,  1'b0, 4'd0, 8'd0},
    '{2'd0, 12'd16, 4'd0, 8'd0,  1'b0, 4'd3, 8'd5},
    '{2'd1, 12'd17, 4'd2, 8'd7,  1'b0, 4'd0, 8'd0},
    '{2'd0, 12'd17, 4'd0, 8'd0,  1'b0, 4'd2, 8'd7},
    '{2'd1, 12'd15, 4'd9, 8'd1,  1'b1, 4'd0, 8'd0},
    '{2'd0, 12'd24, 4'd0, 8'd0,  1'b1, 4'd0, 8'd0},
    '{2'd2, 12'd17, 4'd0, 8'd0,  1'b0, 4'd0, 8'd0},
    '{2'd0, 12'd17, 4'd0, 8'd0,  1'b0, 4'd2, 8'hFF},
    '{2'd3, 12'd17, 4'd0, 8'd0,  1'b0, 4'd0, 8'd0},
    '{2'd0, 12'd17, 4'd0, 8'd0,  1'b0, 4'd2, 8'd7},
    '{2'd1, 12'd20, 4'd5, 8'd2,  1'b0, 4'd0, 8'd0}
  };

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] op, input int num, input int srv, input int prio);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_op = op; cfg_num = 12'(num);
    cfg_srv = 4'(srv); cfg_prio = 8'(prio);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic read_chk(input int num, input int esrv, input int eprio, input string tag);
    cfg(2'd0, num, 0, 0);
    check(cfg_done && !cfg_err && rd_prio == 8'(eprio) && rd_srv == 4'(esrv), tag,
          {rd_srv, rd_prio}, {4'(esrv), 8'(eprio)});
  endtask

  task automatic pulse_src(input logic [7:0] m);
    @(negedge clk); src = src | m;
    @(negedge clk); src = src & ~m;
  endtask

  task automatic set_lvl(input int i, input logic v);
    @(negedge clk); src[i] = v;
    @(negedge clk);
  endtask

  task automatic reject(input int num);
    @(negedge clk); rej_valid = 1'b1; rej_num = 12'(num);
    @(negedge clk); rej_valid = 1'b0;
  endtask

  task automatic eoi(input int num);
    @(negedge clk); eoi_valid = 1'b1; eoi_num = 12'(num);
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic do_resend();
    @(negedge clk); resend = 1'b1;
    @(negedge clk); resend = 1'b0;
  endtask

  task automatic wait_offer();
    for (int k = 0; k < 10; k++) begin
      if (off_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic accept();
    off_ready = 1'b1;
    @(negedge clk);
    off_ready = 1'b0;
  endtask

  task automatic expect_offer(input int num, input int srv, input int prio, input string tag);
    wait_offer();
    check(off_valid && off_num == 12'(num) && off_srv == 4'(srv) && off_prio == 8'(prio),
          tag, off_valid ? int'(off_num) : -1, num);
    if (off_valid) accept();
  endtask

  task automatic expect_none(input int cycles, input string tag);
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (off_valid) seen = 1'b1;
    end
    check(!seen, tag, int'(seen), 0);
    if (seen) accept();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!off_valid && !cfg_done, "R1 idle after reset", int'(off_valid), 0);

    // table walk: register port behaviour (R1, R7, R8, R9, R12)
    for (int v = 0; v < 12; v++) begin
      cfg(TBL[v].op, int'(TBL[v].num), int'(TBL[v].srv), int'(TBL[v].prio));
      check(cfg_done && cfg_err == TBL[v].err, "R9 R12 table done/err",
            int'(cfg_err), int'(TBL[v].err));
      if (TBL[v].op == 2'd0 && !TBL[v].err)
        check(rd_srv == TBL[v].esrv && rd_prio == TBL[v].eprio, "R12 R1 R8 table read",
              {rd_srv, rd_prio}, {TBL[v].esrv, TBL[v].eprio});
    end
    expect_none(4, "R3 write to idle level source");

    // R2 message offer and masked pending
    pulse_src(8'h01);
    expect_offer(16, 3, 5, "R2 unmasked message offer");
    pulse_src(8'h04);
    expect_none(6, "R2 masked message not offered");
    cfg(2'd1, 18, 1, 4);
    expect_offer(18, 1, 4, "R7 unmask releases pending");
    cfg(2'd1, 18, 1, 4);
    expect_none(5, "R7 pending cleared after release");

    // R3 level source
    set_lvl(4, 1'b1);
    expect_offer(20, 5, 2, "R3 level rise offered");
    set_lvl(4, 1'b0);
    set_lvl(4, 1'b1);
    expect_none(5, "R3 no reoffer while sent");

    // R5 EOI re-arms only on next level change
    eoi(20);
    expect_none(4, "R5 EOI alone does not offer");
    set_lvl(4, 1'b0);
    set_lvl(4, 1'b1);
    expect_offer(20, 5, 2, "R5 offer after EOI and rise");

    // R4 reject, R5 EOI on message, R6 resend, R10/R11 hold
    reject(16);
    eoi(16);
    reject(19);
    reject(20);
    expect_none(5, "R4 reject does not reoffer");
    do_resend();
    wait_offer();
    repeat (5) @(negedge clk);
    check(off_valid && off_num == 12'd16 && off_prio == 8'd5, "R10 R11 held first scan offer",
          int'(off_num), 16);
    accept();
    expect_offer(20, 5, 2, "R6 level reoffered in index order");
    expect_none(14, "R6 masked rejected and clean sources skipped");

    // R10 simultaneous strobes leave in index order
    pulse_src(8'h03);
    expect_offer(16, 3, 5, "R10 lowest index first");
    expect_offer(17, 2, 7, "R10 second index next");

    // R8 off/on with pending event
    cfg(2'd2, 16, 0, 0);
    read_chk(16, 3, 255, "R8 off parks priority");
    pulse_src(8'h01);
    expect_none(5, "R8 event while off");
    cfg(2'd3, 16, 0, 0);
    expect_offer(16, 3, 5, "R8 on restores and releases pending");
    cfg(2'd2, 20, 0, 0);
    read_chk(20, 5, 255, "R8 level off");
    cfg(2'd3, 20, 0, 0);
    read_chk(20, 5, 2, "R8 level on");
    expect_none(4, "R8 sent level not reoffered on");

    // R9 error leaves state
    cfg(2'd1, 24, 7, 1);
    check(cfg_err, "R9 high number error", int'(cfg_err), 1);
    read_chk(23, 0, 255, "R9 neighbour unchanged");

    finish_run();
  end
endmodule